// File: doc/BRIEF.md
# Zero-Overhead Repeat and Loop Sequencer

This block sits beside a DSP program counter and handles repetition in hardware, so that repeated code costs no branch instructions. It has two independent single-instruction repeat counters, a primary and a secondary one. While either is running, the block raises a signal that holds instruction fetch, so the instruction already fetched executes once per step. It also runs a block loop, which is bounded by a start and an end address and counted in passes. When the instruction at the end address completes and more passes remain, the block overrides the next program counter with the start address in the same cycle.

The context of the block loop (its start, end, remaining pass count and active flag) can be saved and restored only through push and pop strobes. The saved contexts go onto a small stack, two entries deep by default, so loops can be nested. The decoder supplies the start commands and the `step_i` strobe, which marks that the instruction at `pc_i` completes in this cycle. Instruction decode and program memory are outside the block.

The repeat engine has three states. REP_IDLE goes to REP_PRIMARY on `rep_go`. It goes to REP_SECONDARY on `rep2_go` when `rep_go` is low. Each run state returns to REP_IDLE on the step that finds its counter at one. The block loop has two states. BLK_IDLE goes to BLK_RUN on `blk_go`, or on a pop that restores an active context. BLK_RUN goes back to BLK_IDLE on the last pass, or on a pop that restores an inactive context.

Top module: `zol_sequencer`

## Requirements
- R1: After reset, `fetch_hold`, `pc_load` and `loop_active` are all low.
- R2: `rep_go` with count N ≥ 1 raises `fetch_hold` from the next cycle. `fetch_hold` falls after exactly N cycles in which `step_i` is high.
- R3: A count of zero behaves exactly like a count of one, for both repeat counters and for the block loop.
- R4: `rep2_go` starts the secondary counter in the same way as R2. When `rep_go` and `rep2_go` arrive in the same cycle, the primary counter wins.
- R5: A repeat start command that arrives while a repeat is running is ignored. The running repeat keeps its own length.
- R6: Cycles with `step_i` low do not consume repeat steps.
- R7: While the loop is active, a step at the end address with more than one pass left makes `pc_load` high and `pc_next` equal to the start address in that same cycle. One pass is consumed at that step. A count of N gives N passes, that is, N−1 redirects.
- R8: On the last pass the end step leaves `pc_load` low, and `loop_active` is low from the next cycle.
- R9: While `fetch_hold` is high, steps at the end address neither redirect nor consume passes. The first step after the repeat ends does.
- R10: `ctx_push` saves the current loop context and `ctx_pop` restores the most recently saved one. With the default depth, two levels nest.
- R11: A push when the stack is full, and a pop when it is empty, are ignored. A push and a pop in the same cycle are also ignored.
- R12: When a pop and `blk_go` arrive in the same cycle, the pop wins and the new loop is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | AW | Address of the instruction completing this cycle |
| step_i | input | 1 | An instruction completes this cycle |
| rep_go | input | 1 | Start the primary repeat |
| rep_count | input | CW | Primary repeat count |
| rep2_go | input | 1 | Start the secondary repeat |
| rep2_count | input | CW | Secondary repeat count |
| blk_go | input | 1 | Start a block loop |
| blk_start | input | AW | Loop start address |
| blk_end | input | AW | Loop end address |
| blk_count | input | CW | Loop pass count |
| ctx_push | input | 1 | Save the loop context |
| ctx_pop | input | 1 | Restore the loop context |
| pc_load | output | 1 | Override the next program counter |
| pc_next | output | AW | Override address (loop start) |
| fetch_hold | output | 1 | Hold instruction fetch (repeat running) |
| loop_active | output | 1 | Block loop running |

## Verification
The bench targets counts of zero and one. A design that mishandled them would hold fetch for a whole counter wrap, or would never release fetch. It also stalls `step_i` in the middle of a repeat, because a design that counted cycles instead of steps would release the fetch unit too early. It collides start commands to check priority and the ignoring of new starts: a wrong design would lengthen or switch the running repeat. It places the end address under a repeat, where a wrong design would wrap on every repeated execution. Finally, it drives the context stack past full and past empty, and pops in the same cycle as a new loop start. Any of these faults shows up as a wrong `pc_next` target, or as the wrong number of redirects when the restored loop is run out.

// File: rtl/zol_pkg.sv
package zol_pkg;
    typedef enum logic [1:0] {
        REP_IDLE      = 2'd0,
        REP_PRIMARY   = 2'd1,
        REP_SECONDARY = 2'd2
    } rep_state_e;

    typedef enum logic {
        BLK_IDLE = 1'b0,
        BLK_RUN  = 1'b1
    } blk_state_e;
endpackage

// File: rtl/zol_repeat_fsm.sv
module zol_repeat_fsm
    import zol_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          pri_go_i,
    input  logic [CW-1:0] pri_count_i,
    input  logic          sec_go_i,
    input  logic [CW-1:0] sec_count_i,
    output logic          busy_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    rep_state_e    state_q, state_d;
    logic [CW-1:0] pri_q, sec_q;
    logic [CW-1:0] pri_load, sec_load;

    // zero count means one execution
    assign pri_load = (pri_count_i == '0) ? ONE : pri_count_i;
    assign sec_load = (sec_count_i == '0) ? ONE : sec_count_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REP_IDLE: begin
                if (pri_go_i)      state_d = REP_PRIMARY;
                else if (sec_go_i) state_d = REP_SECONDARY;
            end
            REP_PRIMARY:   if (step_i && pri_q == ONE) state_d = REP_IDLE;
            REP_SECONDARY: if (step_i && sec_q == ONE) state_d = REP_IDLE;
            default:       state_d = REP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_q <= '0;
            sec_q <= '0;
        end else begin
            if (state_q == REP_IDLE && pri_go_i)
                pri_q <= pri_load;
            else if (state_q == REP_PRIMARY && step_i)
                pri_q <= pri_q - ONE;

            if (state_q == REP_IDLE && sec_go_i && !pri_go_i)
                sec_q <= sec_load;
            else if (state_q == REP_SECONDARY && step_i)
                sec_q <= sec_q - ONE;
        end
    end

    always_comb begin
        busy_o = (state_q != REP_IDLE);
    end

    AST_PRI_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == REP_PRIMARY |-> pri_q != '0); // R2
    AST_PRI_STEP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REP_PRIMARY && step_i) |=> pri_q == $past(pri_q) - ONE); // R2
    AST_SEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == REP_SECONDARY |-> sec_q != '0); // R4
    AST_SEC_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == REP_PRIMARY |=> $stable(sec_q)); // R5
    AST_NO_STEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != REP_IDLE && !step_i) |=> ($stable(pri_q) && $stable(sec_q))); // R6
endmodule

// File: rtl/zol_ctx_stack.sv
module zol_ctx_stack #(
    parameter int W     = 50,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic         pop_ok_o,
    output logic [W-1:0] dout_o
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [LW-1:0] level_q;
    logic          push_ok;

    assign push_ok  = push_i && !pop_i && (level_q < FULL);
    assign pop_ok_o = pop_i && !push_i && (level_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        level_q <= '0;
        else if (push_ok)  level_q <= level_q + LW'(1);
        else if (pop_ok_o) level_q <= level_q - LW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mem_q[g] <= '0;
            else if (push_ok && level_q == LW'(g))    mem_q[g] <= din_i;
        end
    end

    always_comb begin
        dout_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level_q == LW'(i + 1)) dout_o = mem_q[i];
        end
    end

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL); // R11
    AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && level_q == FULL) |=> level_q == FULL); // R11
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && level_q == '0) |=> level_q == '0); // R11
endmodule

// File: rtl/zol_block_loop.sv
module zol_block_loop
    import zol_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          hold_i,
    input  logic [AW-1:0] pc_i,
    input  logic          go_i,
    input  logic [AW-1:0] go_start_i,
    input  logic [AW-1:0] go_end_i,
    input  logic [CW-1:0] go_count_i,
    input  logic          restore_i,
    input  logic          rs_active_i,
    input  logic [AW-1:0] rs_start_i,
    input  logic [AW-1:0] rs_end_i,
    input  logic [CW-1:0] rs_count_i,
    output logic          active_o,
    output logic [AW-1:0] start_o,
    output logic [AW-1:0] end_o,
    output logic [CW-1:0] count_o,
    output logic          redirect_o,
    output logic [AW-1:0] target_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    blk_state_e    state_q, state_d;
    logic [AW-1:0] start_q, end_q;
    logic [CW-1:0] cnt_q;
    logic          at_end;
    logic          last_pass;

    // end steps under a running repeat are not loop steps
    assign at_end    = step_i && !hold_i && (pc_i == end_q);
    assign last_pass = (cnt_q <= ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BLK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restore_i) begin
            state_d = rs_active_i ? BLK_RUN : BLK_IDLE;
        end else if (go_i) begin
            state_d = BLK_RUN;
        end else begin
            unique case (state_q)
                BLK_IDLE: state_d = BLK_IDLE;
                BLK_RUN:  if (at_end && last_pass) state_d = BLK_IDLE;
                default:  state_d = BLK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
            cnt_q   <= '0;
        end else if (restore_i) begin
            start_q <= rs_start_i;
            end_q   <= rs_end_i;
            cnt_q   <= rs_count_i;
        end else if (go_i) begin
            start_q <= go_start_i;
            end_q   <= go_end_i;
            cnt_q   <= (go_count_i == '0) ? ONE : go_count_i;
        end else if (state_q == BLK_RUN && at_end && !last_pass) begin
            cnt_q   <= cnt_q - ONE;
        end
    end

    always_comb begin
        active_o   = (state_q == BLK_RUN);
        start_o    = start_q;
        end_o      = end_q;
        count_o    = cnt_q;
        redirect_o = (state_q == BLK_RUN) && at_end && !last_pass;
        target_o   = start_q;
    end

    AST_REDIRECT_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !restore_i && !go_i) |=> cnt_q == $past(cnt_q) - ONE); // R7
    AST_LAST_PASS_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && at_end && last_pass && !restore_i && !go_i) |=> !active_o); // R8
    AST_HELD_END_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !restore_i && !go_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer #(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int NEST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] pc_i,
    input  logic          step_i,
    input  logic          rep_go,
    input  logic [CW-1:0] rep_count,
    input  logic          rep2_go,
    input  logic [CW-1:0] rep2_count,
    input  logic          blk_go,
    input  logic [AW-1:0] blk_start,
    input  logic [AW-1:0] blk_end,
    input  logic [CW-1:0] blk_count,
    input  logic          ctx_push,
    input  logic          ctx_pop,
    output logic          pc_load,
    output logic [AW-1:0] pc_next,
    output logic          fetch_hold,
    output logic          loop_active
);
    localparam int CTXW = 1 + 2 * AW + CW;

    logic            rep_busy;
    logic            lp_active;
    logic [AW-1:0]   lp_start, lp_end;
    logic [CW-1:0]   lp_count;
    logic            lp_redirect;
    logic [AW-1:0]   lp_target;
    logic [CTXW-1:0] ctx_save, ctx_back;
    logic            ctx_restore;
    logic            blk_go_eff;

    assign ctx_save   = {lp_active, lp_start, lp_end, lp_count};
    assign blk_go_eff = blk_go && !ctx_restore;

    zol_repeat_fsm #(.CW(CW)) u_rep (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .pri_go_i    (rep_go),
        .pri_count_i (rep_count),
        .sec_go_i    (rep2_go),
        .sec_count_i (rep2_count),
        .busy_o      (rep_busy)
    );

    zol_ctx_stack #(.W(CTXW), .DEPTH(NEST)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (ctx_push),
        .pop_i    (ctx_pop),
        .din_i    (ctx_save),
        .pop_ok_o (ctx_restore),
        .dout_o   (ctx_back)
    );

    zol_block_loop #(.AW(AW), .CW(CW)) u_loop (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .hold_i      (rep_busy),
        .pc_i        (pc_i),
        .go_i        (blk_go_eff),
        .go_start_i  (blk_start),
        .go_end_i    (blk_end),
        .go_count_i  (blk_count),
        .restore_i   (ctx_restore),
        .rs_active_i (ctx_back[CTXW-1]),
        .rs_start_i  (ctx_back[CTXW-2 -: AW]),
        .rs_end_i    (ctx_back[CW+AW-1 -: AW]),
        .rs_count_i  (ctx_back[CW-1:0]),
        .active_o    (lp_active),
        .start_o     (lp_start),
        .end_o       (lp_end),
        .count_o     (lp_count),
        .redirect_o  (lp_redirect),
        .target_o    (lp_target)
    );

    always_comb begin
        pc_load     = lp_redirect;
        pc_next     = lp_target;
        fetch_hold  = rep_busy;
        loop_active = lp_active;
    end

    AST_HOLD_BLOCKS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold |-> !pc_load); // R9
    AST_LOAD_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> loop_active); // R7
    AST_POP_BEATS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_restore && blk_go) |=> loop_active == $past(ctx_back[CTXW-1])); // R12
endmodule

// File: tb/sim_zol_sequencer.sv
module sim_zol_sequencer;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pc_i = '0;
    logic          step_i = 1'b0;
    logic          rep_go = 1'b0;
    logic [CW-1:0] rep_count = '0;
    logic          rep2_go = 1'b0;
    logic [CW-1:0] rep2_count = '0;
    logic          blk_go = 1'b0;
    logic [AW-1:0] blk_start = '0;
    logic [AW-1:0] blk_end = '0;
    logic [CW-1:0] blk_count = '0;
    logic          ctx_push = 1'b0;
    logic          ctx_pop = 1'b0;
    logic          pc_load;
    logic [AW-1:0] pc_next;
    logic          fetch_hold;
    logic          loop_active;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    zol_sequencer #(.AW(AW), .CW(CW), .NEST(2)) u0 (.*);

    // {select (0 primary, 1 secondary), count, expected steps}
    localparam logic [47:0] VEC [0:6] = '{
        {16'd0, 16'd0,  16'd1},
        {16'd0, 16'd1,  16'd1},
        {16'd0, 16'd5,  16'd5},
        {16'd1, 16'd0,  16'd1},
        {16'd1, 16'd3,  16'd3},
        {16'd1, 16'd17, 16'd17},
        {16'd0, 16'd2,  16'd2}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_hold(output int n);
        n = 0;
        while (fetch_hold && n < 1000) begin
            n++;
            tick();
        end
    endtask

    task automatic run_loop(input int s, input int e, input int c, output int redirs);
        logic [AW-1:0] pc;
        int guard;
        blk_go = 1'b1; blk_start = AW'(s); blk_end = AW'(e); blk_count = CW'(c);
        tick();
        blk_go = 1'b0;
        pc = AW'(s);
        redirs = 0;
        guard = 0;
        step_i = 1'b1;
        while (pc != AW'(e + 1) && guard < 1000) begin
            logic [AW-1:0] nx;
            pc_i = pc;
            #1;
            if (pc_load) begin
                redirs++;
                check(pc_next == AW'(s), "R7 redirect target", int'(pc_next), s);
            end
            nx = pc_load ? pc_next : pc + AW'(1);
            tick();
            pc = nx;
            guard++;
        end
        step_i = 1'b0;
    endtask

    task automatic peek(input int e, input bit exp_load, input int exp_tgt, input string tag);
        pc_i = AW'(e);
        step_i = 1'b1;
        #1;
        check(pc_load == exp_load, tag, int'(pc_load), int'(exp_load));
        if (exp_load)
            check(pc_next == AW'(exp_tgt), tag, int'(pc_next), exp_tgt);
        step_i = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        #1;
        // R1: reset values
        check(!fetch_hold && !pc_load && !loop_active, "R1 reset outputs",
              int'({fetch_hold, pc_load, loop_active}), 0);
        tick();
        rst_n = 1'b1;
        tick();

        // R2 R3 R4: table of repeat lengths
        for (int i = 0; i < 7; i++) begin
            if (VEC[i][47:32] == 16'd0) begin
                rep_go = 1'b1; rep_count = VEC[i][31:16];
            end else begin
                rep2_go = 1'b1; rep2_count = VEC[i][31:16];
            end
            tick();
            rep_go = 1'b0; rep2_go = 1'b0;
            step_i = 1'b1;
            count_hold(n);
            step_i = 1'b0;
            check(n == int'(VEC[i][15:0]), "R2/R3/R4 repeat step count", n, int'(VEC[i][15:0]));
            tick();
        end

        // R6: stalled steps are not consumed
        rep_go = 1'b1; rep_count = 16'd3;
        tick();
        rep_go = 1'b0;
        repeat (4) tick();
        check(fetch_hold == 1'b1, "R6 hold kept without steps", int'(fetch_hold), 1);
        step_i = 1'b1;
        count_hold(n);
        step_i = 1'b0;
        check(n == 3, "R6 steps after stall", n, 3);

        // R4: primary wins a same-cycle start
        rep_go = 1'b1; rep_count = 16'd2; rep2_go = 1'b1; rep2_count = 16'd6;
        tick();
        rep_go = 1'b0; rep2_go = 1'b0;
        step_i = 1'b1;
        count_hold(n);
        step_i = 1'b0;
        check(n == 2, "R4 primary priority", n, 2);

        // R5: start during a running repeat is ignored
        rep_go = 1'b1; rep_count = 16'd4;
        tick();
        rep_go = 1'b0;
        step_i = 1'b1;
        tick();
        rep2_go = 1'b1; rep2_count = 16'd10;
        tick();
        rep2_go = 1'b0;
        count_hold(n);
        step_i = 1'b0;
        check(n == 2, "R5 restart ignored", n, 2);
        tick();
        check(fetch_hold == 1'b0, "R5 no late secondary", int'(fetch_hold), 0);

        // R7 R8 R3: block loop pass counts
        run_loop(16'h10, 16'h13, 3, n);
        check(n == 2, "R7 three passes", n, 2);
        check(loop_active == 1'b0, "R8 loop ends", int'(loop_active), 0);
        run_loop(16'h30, 16'h30, 4, n);
        check(n == 3, "R7 single-address loop", n, 3);
        run_loop(16'h50, 16'h52, 0, n);
        check(n == 0, "R3 zero-count loop", n, 0);
        check(loop_active == 1'b0, "R8 zero-count loop ends", int'(loop_active), 0);

        // R9: end address under a repeat
        blk_go = 1'b1; blk_start = 16'h20; blk_end = 16'h21; blk_count = 16'd2;
        tick();
        blk_go = 1'b0;
        rep_go = 1'b1; rep_count = 16'd3; pc_i = 16'h21;
        tick();
        rep_go = 1'b0;
        step_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(pc_load == 1'b0, "R9 no wrap under hold", int'(pc_load), 0);
            tick();
        end
        #1;
        check(pc_load == 1'b1 && pc_next == 16'h20, "R9 wrap after repeat",
              int'(pc_next), 16'h20);
        tick();
        #1;
        check(pc_load == 1'b0, "R9 pass count kept", int'(pc_load), 0);
        step_i = 1'b0;
        tick();

        // R10 R11: nesting, overflow and underflow
        blk_go = 1'b1; blk_start = 16'h100; blk_end = 16'h1FF; blk_count = 16'd5;
        tick();
        blk_go = 1'b0; ctx_push = 1'b1;
        tick();
        ctx_push = 1'b0;
        blk_go = 1'b1; blk_start = 16'h200; blk_end = 16'h2FF; blk_count = 16'd4;
        tick();
        ctx_push = 1'b1;
        blk_start = 16'h300; blk_end = 16'h3FF; blk_count = 16'd3;
        tick();
        blk_go = 1'b0;
        tick();
        ctx_push = 1'b0;
        peek(16'h3FF, 1'b1, 16'h300, "R10 innermost loop");
        ctx_pop = 1'b1;
        tick();
        ctx_pop = 1'b0;
        check(loop_active == 1'b1, "R10 restored active", int'(loop_active), 1);
        peek(16'h2FF, 1'b1, 16'h200, "R10 middle restored");
        ctx_pop = 1'b1;
        tick();
        ctx_pop = 1'b0;
        peek(16'h1FF, 1'b1, 16'h100, "R10 outer restored");
        ctx_pop = 1'b1;
        tick();
        ctx_pop = 1'b0;
        peek(16'h1FF, 1'b1, 16'h100, "R11 empty pop ignored");

        // R12: pop beats a new loop start
        ctx_push = 1'b1;
        tick();
        ctx_push = 1'b0;
        ctx_pop = 1'b1; blk_go = 1'b1;
        blk_start = 16'h500; blk_end = 16'h5FF; blk_count = 16'd2;
        tick();
        ctx_pop = 1'b0; blk_go = 1'b0;
        peek(16'h1FF, 1'b1, 16'h100, "R12 pop wins");

        // R10: restored pass count (5) yields four redirects
        n = 0;
        pc_i = 16'h1FF;
        step_i = 1'b1;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (pc_load) n++;
            tick();
        end
        step_i = 1'b0;
        check(n == 4, "R10 restored pass count", n, 4);
        check(loop_active == 1'b0, "R8 restored loop ends", int'(loop_active), 0);

        // R1: reset in the middle of activity
        blk_go = 1'b1; blk_count = 16'd9; rep_go = 1'b1; rep_count = 16'd9;
        tick();
        blk_go = 1'b0; rep_go = 1'b0;
        rst_n = 1'b0;
        #1;
        check(!fetch_hold && !loop_active, "R1 reset clears activity",
              int'({fetch_hold, loop_active}), 0);
        tick();
        rst_n = 1'b1;
        tick();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule